// File: doc/BRIEF.md
# Blanking-Synchronized Screen RAM Loader

This block takes character updates from an external programming port and stores them in a character screen RAM without ever interrupting the picture. A writer places a screen position and a character code together on one 12-bit bus and raises a strobe. The strobe is asynchronous to the block clock. The block synchronizes the strobe, copies the bus into holding registers and marks an update as pending.

An internal slot timer divides time into 50 us character slots. The last quarter of each slot is a blanking window with the beam cut off. A scan counter steps through the 128 screen positions, one per slot. During the visible part of a slot the RAM is read at the scan position, and the stored code selects the glyph. During blanking the port is locked out and any pending update is written into the RAM. The single RAM port therefore never sees a read and a write in the same cycle.

An external writer must hold the strobe longer than one blanking window plus the synchronizer delay. This guarantees capture even when the strobe rises at the very start of blanking.

Top module: `blank_loader`

## Requirements
- R1: While `rstN` is low, and on the first cycle after reset, `blanking`, `pending`, `scanPos` and `glyphCode` are all 0.
- R2: A slot lasts SLOT_CYC = CLK_HZ/20000 clock cycles. `blanking` is low for the first SLOT_CYC - SLOT_CYC/4 cycles of each slot and high for the remaining SLOT_CYC/4 cycles. `scanPos` advances by one at the end of every slot and wraps from 127 to 0.
- R3: `updBus[11:5]` carries the screen position and `updBus[4:0]` carries the 5-bit character code.
- R4: `updStrobe` passes through a two-flop synchronizer. When the synchronized strobe is high, the block is armed, and `blanking` is low, the bus is captured and `pending` is set. `pending` is high no later than 4 cycles after the strobe rises during the visible part of a slot.
- R5: While `blanking` is high the strobe has no effect. A pulse that lies wholly inside blanking is lost. A strobe still held when blanking ends is captured right after blanking ends.
- R6: A pending update is written into the RAM on the first cycle of the next blanking window, and `pending` is cleared at that same edge. No RAM write happens outside blanking or when nothing is pending.
- R7: From the second visible cycle of a slot, `glyphCode` equals the code stored at `scanPos`. `glyphCode` holds its value throughout blanking.
- R8: The strobe held high is captured only once. A new capture needs the synchronized strobe to go low first, so bus changes made while the strobe stays high are not stored.
- R9: When two captures occur before one blanking window, only the later position and code are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_HZ |
| rstN | input | 1 | Active-low synchronous reset |
| updBus | input | 12 | Update bus: position in [11:5], code in [4:0] |
| updStrobe | input | 1 | Asynchronous update strobe, active high |
| blanking | output | 1 | High during the blanking part of a slot |
| scanPos | output | 7 | Screen position currently being displayed |
| glyphCode | output | 5 | Character code read for the current position |
| pending | output | 1 | An update is captured and not yet written |

## Verification
The bench builds the block with CLK_HZ = 800000. This gives a 40-cycle slot with a 10-cycle blanking window, so a whole 128-position frame takes about 5000 cycles. At that size every RAM position can be written and then read back over complete frames, and the scan wrap is observed. Strobes are placed at exact slot phases: rising on the first blanking cycle, short pulses inside blanking, a double capture within one visible window, and a strobe held across several slots.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef struct packed {
    logic capture;
    logic commit;
    logic readEn;
  } ctrlStb_t;
endpackage

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000,
  parameter int POS_W  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strobeAsync,
  output logic             blanking,
  output logic             pending,
  output logic [POS_W-1:0] scanPos,
  output ctrlStb_t         stb
);
  localparam int SLOT_CYC    = CLK_HZ / 20000;
  localparam int BLANK_CYC   = SLOT_CYC / 4;
  localparam int BLANK_START = SLOT_CYC - BLANK_CYC;
  localparam int CNT_W       = $clog2(SLOT_CYC);

  logic [CNT_W-1:0] slotCnt;
  logic             slotEnd;
  logic             syncA, syncB, armed;
  logic             captureNow, commitNow;

  // slot timer and scan position
  assign slotEnd  = (slotCnt == CNT_W'(SLOT_CYC - 1));
  assign blanking = (slotCnt >= CNT_W'(BLANK_START));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
      scanPos <= '0;
    end else begin
      slotCnt <= slotEnd ? '0 : slotCnt + 1'b1;
      if (slotEnd) scanPos <= scanPos + 1'b1;
    end
  end

  // strobe synchronizer and one-shot arming
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= strobeAsync;
      syncB <= syncA;
    end
  end

  assign captureNow = syncB & armed & ~blanking;
  assign commitNow  = pending & (slotCnt == CNT_W'(BLANK_START));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b1;
      pending <= 1'b0;
    end else begin
      if (!syncB)          armed <= 1'b1;
      else if (captureNow) armed <= 1'b0;
      if (captureNow)      pending <= 1'b1;
      else if (commitNow)  pending <= 1'b0;
    end
  end

  always_comb begin
    stb.capture = captureNow;
    stb.commit  = commitNow;
    stb.readEn  = ~blanking;
  end
endmodule

// File: rtl/loader_dp.sv
module loader_dp
  import loader_pkg::*;
#(
  parameter int POS_W  = 7,
  parameter int CODE_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [POS_W+CODE_W-1:0] busIn,
  input  logic [POS_W-1:0]        scanPos,
  input  ctrlStb_t                stb,
  output logic [CODE_W-1:0]       glyphCode
);
  localparam int DEPTH = 1 << POS_W;

  logic [POS_W-1:0]  posQ;
  logic [CODE_W-1:0] codeQ;
  logic [CODE_W-1:0] screenMem [DEPTH];

  // holding registers for the captured pair
  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ  <= '0;
      codeQ <= '0;
    end else if (stb.capture) begin
      posQ  <= busIn[POS_W+CODE_W-1:CODE_W];
      codeQ <= busIn[CODE_W-1:0];
    end
  end

  // single-port screen RAM: write in blanking, read when visible
  always_ff @(posedge clk) begin
    if (stb.commit) screenMem[posQ] <= codeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           glyphCode <= '0;
    else if (stb.readEn) glyphCode <= screenMem[scanPos];
  end
endmodule

// File: rtl/blank_loader.sv
module blank_loader
  import loader_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000,
  parameter int POS_W  = 7,
  parameter int CODE_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [POS_W+CODE_W-1:0] updBus,
  input  logic                    updStrobe,
  output logic                    blanking,
  output logic [POS_W-1:0]        scanPos,
  output logic [CODE_W-1:0]       glyphCode,
  output logic                    pending
);
  ctrlStb_t stb;

  loader_ctrl #(.CLK_HZ(CLK_HZ), .POS_W(POS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .strobeAsync(updStrobe),
    .blanking(blanking), .pending(pending), .scanPos(scanPos), .stb(stb)
  );

  loader_dp #(.POS_W(POS_W), .CODE_W(CODE_W)) uDp (
    .clk(clk), .rstN(rstN), .busIn(updBus), .scanPos(scanPos),
    .stb(stb), .glyphCode(glyphCode)
  );
endmodule

// File: rtl/loader_chk.sv
module loader_chk
  import loader_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000,
  parameter int POS_W  = 7,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              blanking,
  input logic              pending,
  input logic [POS_W-1:0]  scanPos,
  input logic [CODE_W-1:0] glyphCode,
  input ctrlStb_t          stb
);
  localparam int SLOT_CYC  = CLK_HZ / 20000;
  localparam int BLANK_CYC = SLOT_CYC / 4;

  int blankRun, visRun;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blankRun <= 0;
      visRun   <= 0;
    end else begin
      blankRun <= blanking ? blankRun + 1 : 0;
      visRun   <= blanking ? 0 : visRun + 1;
    end
  end

  a_r2_blank_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(blanking) |-> blankRun == BLANK_CYC);
  a_r2_visible_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blanking) |-> visRun == SLOT_CYC - BLANK_CYC);
  a_r2_scan_step: assert property (@(posedge clk) disable iff (!rstN)
    (scanPos != $past(scanPos)) |-> (scanPos == POS_W'($past(scanPos) + 1)));
  a_r4_pending_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(stb.capture));
  a_r5_no_capture_blank: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> !blanking);
  a_r6_write_in_blank: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> blanking && pending);
  a_r6_pending_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !pending);
  a_r7_glyph_hold: assert property (@(posedge clk) disable iff (!rstN)
    (blanking && $past(blanking)) |-> $stable(glyphCode));
endmodule

bind blank_loader loader_chk #(.CLK_HZ(CLK_HZ), .POS_W(POS_W), .CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .blanking(blanking), .pending(pending),
  .scanPos(scanPos), .glyphCode(glyphCode), .stb(stb)
);

// File: tb/tb_blank_loader.sv
module tb_blank_loader;
  localparam int CLK_HZ    = 800000;
  localparam int SLOT_CYC  = CLK_HZ / 20000;
  localparam int BLANK_CYC = SLOT_CYC / 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] updBus;
  logic        updStrobe;
  logic        blanking, pending;
  logic [6:0]  scanPos;
  logic [4:0]  glyphCode;

  int nCmp = 0;
  int nBad = 0;
  int expMem [128];

  always #2 clk = ~clk;

  blank_loader #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rstN(rstN), .updBus(updBus), .updStrobe(updStrobe),
    .blanking(blanking), .scanPos(scanPos), .glyphCode(glyphCode), .pending(pending)
  );

  task automatic chk(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitRise();
    while (blanking) @(negedge clk);
    while (!blanking) @(negedge clk);
  endtask

  task automatic waitFall();
    while (!blanking) @(negedge clk);
    while (blanking) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200 && pending; i++) @(negedge clk);
  endtask

  // R3/R4/R6: write one pair starting at a visible slot start
  task automatic doWrite(input int p, input int c, input bit full);
    waitFall();
    updBus = {7'(p), 5'(c)};
    updStrobe = 1'b1;
    repeat (4) @(negedge clk);
    if (full) chk("R4 pending set", int'(pending), 1);
    repeat (2) @(negedge clk);
    updStrobe = 1'b0;
    if (full) begin
      waitRise();
      chk("R6 pending held to blank", int'(pending), 1);
      @(negedge clk);
      chk("R6 pending cleared at commit", int'(pending), 0);
    end
    waitIdle();
    expMem[p] = c;
  endtask

  // R7/R2: scan one whole frame
  task automatic scanFrame();
    int prev;
    waitFall();
    prev = int'(scanPos) - 1;
    for (int s = 0; s < 128; s++) begin
      if (s > 0) waitFall();
      repeat (2) @(negedge clk);
      chk("R2 scan step", int'(scanPos), (prev + 1) % 128);
      prev = int'(scanPos);
      chk("R7 glyph", int'(glyphCode), expMem[scanPos]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int n, g0;
    rstN = 1'b0; updBus = '0; updStrobe = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 blanking", int'(blanking), 0);
    chk("R1 pending", int'(pending), 0);
    chk("R1 scanPos", int'(scanPos), 0);
    chk("R1 glyph", int'(glyphCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 scanPos after release", int'(scanPos), 0);
    chk("R1 blanking after release", int'(blanking), 0);

    // R2: slot phase lengths
    waitFall();
    g0 = int'(scanPos);
    n = 0;
    while (!blanking) begin n++; @(negedge clk); end
    chk("R2 visible length", n, SLOT_CYC - BLANK_CYC);
    n = 0;
    while (blanking) begin n++; @(negedge clk); end
    chk("R2 blank length", n, BLANK_CYC);
    chk("R2 scan advance", int'(scanPos), (g0 + 1) % 128);

    // R3/R4/R6: write every position
    for (int p = 0; p < 128; p++) doWrite(p, (p * 7 + 3) % 32, p < 8);
    scanFrame();

    // R5: strobe rising on the first blanking cycle, held through blanking
    waitRise();
    updBus = {7'd10, 5'd21};
    updStrobe = 1'b1;
    n = 0;
    for (int i = 0; i < BLANK_CYC - 1; i++) begin
      @(negedge clk);
      if (pending) n++;
    end
    chk("R5 no capture in blanking", n, 0);
    waitFall();
    repeat (2) @(negedge clk);
    chk("R5 captured after blanking", int'(pending), 1);
    updStrobe = 1'b0;
    waitIdle();
    expMem[10] = 21;

    // R5: short pulse wholly inside blanking is lost
    waitRise();
    updBus = {7'd20, 5'd9};
    updStrobe = 1'b1;
    repeat (3) @(negedge clk);
    updStrobe = 1'b0;
    waitFall();
    repeat (4) @(negedge clk);
    chk("R5 pulse in blanking ignored", int'(pending), 0);

    // R8: held strobe captures once
    waitFall();
    updBus = {7'd30, 5'd17};
    updStrobe = 1'b1;
    repeat (4) @(negedge clk);
    waitIdle();
    updBus = {7'd31, 5'd2};
    repeat (2 * SLOT_CYC) @(negedge clk);
    chk("R8 no second capture", int'(pending), 0);
    updStrobe = 1'b0;
    expMem[30] = 17;

    // R9: two captures before one blanking window
    waitFall();
    updBus = {7'd40, 5'd1};
    updStrobe = 1'b1;
    repeat (3) @(negedge clk);
    updStrobe = 1'b0;
    repeat (3) @(negedge clk);
    updBus = {7'd41, 5'd29};
    updStrobe = 1'b1;
    repeat (3) @(negedge clk);
    updStrobe = 1'b0;
    chk("R9 still visible", int'(blanking), 0);
    waitIdle();
    expMem[41] = 29;

    scanFrame();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule